// File: doc/BRIEF.md
# Dual-Thread Power State Coordinator

This block follows the power state of two hardware threads and reduces them to one package-level state. Each thread runs in C0. It drops into a halted C1 state on a halt pulse, or into a monitor-wait C1 state on a wait pulse whose sub-state hint selects C1. A thread can also make a read of its power-level I/O register. The block turns that read into a wait request, using the hint held in a software-writable configuration register. The read never appears on the external bus, and no monitor address has to be armed beforehand.

Interrupt, init and management events bring a sleeping thread back to C0. Monitor events do the same, but only for a thread in the wait flavour. A snoop from the bus, or from the sibling thread, moves a sleeping thread into a short snoopable sub-state. The thread returns to the C1 flavour it left once the snoop has been serviced. The package reports a low-power state only while both threads sit in the same C1 flavour. An idle flag follows that condition, with a one-cycle lag on entry and no lag on exit. The instruction pipeline, the monitor hardware and the bus are modelled as single-cycle pulses on the inputs.

Top module: `cstate_coord`

## Requirements
- R1: A synchronous active-high reset forces both threads to C0 (code 00) at the next clock edge, clears pkg_idle and sets the hint register to 0. Reset takes priority over every other input.
- R2: A thread in C0 moves at the next edge to C1-halt (01) on halt_req, or to C1-wait (10) on wait_req when its 4-bit hint (thread t at wait_hint[4t+3:4t]) equals 0, the C1 hint. If halt_req and wait_req arrive together, halt wins. A wait request with any other hint leaves the thread in C0.
- R3: A thread in C1-halt, C1-wait or the snoop sub-state returns to C0 at the next edge when any of its smi_evt, init_evt, nmi_evt, intr_evt or msg_evt bits is high.
- R4: mon_evt returns a C1-wait thread to C0 at the next edge. A C1-halt thread ignores mon_evt.
- R5: When a wake event from R3 arrives in the same cycle as a low-power request, the thread stays in C0 and the request is dropped.
- R6: A thread in either C1 state moves to the snoop sub-state (11) at the next edge when bus_snoop or its peer_snoop bit is high. Halt and wait requests are ignored while a thread is in C1 or in the snoop sub-state.
- R7: The snoop sub-state lasts at least 2 cycles. The thread leaves it at the first edge at which 2 cycles have passed and snoop_done has been seen since entry, and it goes back to the C1 state it came from. A wake event from R3 during the sub-state sends the thread to C0, and so does mon_evt if the thread came from C1-wait.
- R8: A pulse on iord_req acts as a wait request whose hint is the configuration register. That register is written from cfg_wdata when cfg_we is high and takes effect in the next cycle. A non-zero value leaves the thread in C0.
- R9: pkg_state equals the common state when both threads are in the same C1 state (01 or 10), and is 00 otherwise.
- R10: pkg_idle rises one cycle after both threads reach the same C1 state, and falls in the same cycle that either thread leaves it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req | input | 2 | Per-thread halt request pulse |
| wait_req | input | 2 | Per-thread wait request pulse |
| wait_hint | input | 8 | Per-thread 4-bit sub-state hint for wait_req |
| iord_req | input | 2 | Per-thread read of the power-level I/O register |
| cfg_we | input | 1 | Write enable of the hint configuration register |
| cfg_wdata | input | 4 | New hint value |
| smi_evt | input | 2 | Per-thread management interrupt |
| init_evt | input | 2 | Per-thread init event |
| nmi_evt | input | 2 | Per-thread non-maskable interrupt |
| intr_evt | input | 2 | Per-thread maskable interrupt |
| msg_evt | input | 2 | Per-thread bus interrupt message |
| mon_evt | input | 2 | Per-thread monitor event |
| bus_snoop | input | 1 | Snoop from the bus, seen by both threads |
| peer_snoop | input | 2 | Snoop into a thread from its sibling |
| snoop_done | input | 2 | Per-thread snoop serviced |
| thr_state | output | 4 | Thread state, thread t at bits [2t+1:2t] |
| pkg_state | output | 2 | Package state |
| pkg_idle | output | 1 | Both threads share one C1 state |

## Verification
The bench targets four corner cases:
- A halted thread that received a monitor event. A design that woke it would show 00 instead of 01.
- A snoop whose done arrives early or late. A design that ignored the 2-cycle minimum or the done handshake would return to C1 a cycle early or would stay stuck in 11. A design that lost the origin of the snoop would return to the wrong C1 flavour.
- Wake and request pulses that coincide, and I/O reads under a non-C1 configured hint. A wrong design would leave the thread sleeping.
- The moment the threads split. A pkg_idle that was only registered would fall one cycle late, and a package resolver that did not require a common state would report a C1 state.

// File: rtl/cstate_pkg.sv
package cstate_pkg;
  typedef enum logic [1:0] {
    CS_RUN   = 2'b00,
    CS_HALT  = 2'b01,
    CS_WAIT  = 2'b10,
    CS_SNOOP = 2'b11
  } cstate_e;
endpackage

// File: rtl/cs_iord_xlate.sv
// Folds direct wait requests and power-level register reads into one
// per-thread "enter C1-wait" strobe; holds the programmable hint.
module cs_iord_xlate #(
  parameter int NTHR = 2,
  parameter int HINT_W = 4,
  parameter logic [HINT_W-1:0] C1_HINT = '0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [HINT_W-1:0]        cfg_wdata,
  input  logic [NTHR-1:0]          wait_req,
  input  logic [NTHR*HINT_W-1:0]   wait_hint,
  input  logic [NTHR-1:0]          iord_req,
  output logic [NTHR-1:0]          wait_c1
);
  logic [HINT_W-1:0] hint_cfg_q;

  always_ff @(posedge clk) begin
    if (rst)         hint_cfg_q <= C1_HINT;
    else if (cfg_we) hint_cfg_q <= cfg_wdata;
  end

  for (genvar t = 0; t < NTHR; t++) begin : g_xl
    logic direct_c1, iord_c1;
    assign direct_c1  = wait_req[t] && (wait_hint[t*HINT_W +: HINT_W] == C1_HINT);
    assign iord_c1    = iord_req[t] && (hint_cfg_q == C1_HINT);
    assign wait_c1[t] = direct_c1 || iord_c1;
  end
endmodule

// File: rtl/cs_thread_fsm.sv
// One thread's power state with snoop sub-state and return memory.
module cs_thread_fsm
  import cstate_pkg::*;
#(
  parameter int SNP_MIN = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    hard_wake,
  input  logic    mon_evt,
  input  logic    halt_req,
  input  logic    wait_c1,
  input  logic    snoop,
  input  logic    snoop_done,
  output cstate_e state
);
  localparam int CW = (SNP_MIN > 2) ? $clog2(SNP_MIN) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(SNP_MIN - 1);

  cstate_e        st_q, st_d;
  logic           from_wait_q, from_wait_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           done_q, done_d;
  logic           snp_ready;

  always_comb begin
    st_d        = st_q;
    from_wait_d = from_wait_q;
    cnt_d       = cnt_q;
    done_d      = done_q;
    snp_ready   = (cnt_q >= CNT_LAST) && (done_q || snoop_done);
    unique case (st_q)
      CS_RUN: begin
        // a same-cycle wake cancels any request
        if (!hard_wake) begin
          if (halt_req)     st_d = CS_HALT;
          else if (wait_c1) st_d = CS_WAIT;
        end
      end
      CS_HALT, CS_WAIT: begin
        if (hard_wake || (st_q == CS_WAIT && mon_evt)) begin
          st_d = CS_RUN;
        end else if (snoop) begin
          st_d        = CS_SNOOP;
          from_wait_d = (st_q == CS_WAIT);
          cnt_d       = '0;
          done_d      = 1'b0;
        end
      end
      default: begin
        if (hard_wake || (from_wait_q && mon_evt)) begin
          st_d = CS_RUN;
        end else if (snp_ready) begin
          st_d = from_wait_q ? CS_WAIT : CS_HALT;
        end else begin
          if (cnt_q != CNT_LAST) cnt_d = cnt_q + CW'(1);
          done_d = done_q || snoop_done;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= CS_RUN;
      from_wait_q <= 1'b0;
      cnt_q       <= '0;
      done_q      <= 1'b0;
    end else begin
      st_q        <= st_d;
      from_wait_q <= from_wait_d;
      cnt_q       <= cnt_d;
      done_q      <= done_d;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/cs_pkg_resolve.sv
// Package state: a C1 flavour only when every thread shares it.
module cs_pkg_resolve
  import cstate_pkg::*;
#(
  parameter int NTHR = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2*NTHR-1:0]   thr_state,
  output logic [1:0]          pkg_state,
  output logic                pkg_idle
);
  logic [NTHR-1:0] match;
  logic [1:0]      lead;
  logic            common_low;
  logic            idle_q;

  assign lead = thr_state[1:0];
  for (genvar t = 0; t < NTHR; t++) begin : g_m
    assign match[t] = (thr_state[2*t +: 2] == lead);
  end

  assign common_low = (&match) && (lead == 2'(CS_HALT) || lead == 2'(CS_WAIT));
  assign pkg_state  = common_low ? lead : 2'(CS_RUN);

  always_ff @(posedge clk) begin
    if (rst) idle_q <= 1'b0;
    else     idle_q <= common_low;
  end

  // delayed rise, immediate fall
  assign pkg_idle = idle_q && common_low;
endmodule

// File: rtl/cstate_coord.sv
module cstate_coord
  import cstate_pkg::*;
#(
  parameter int NTHR = 2,
  parameter int HINT_W = 4,
  parameter logic [HINT_W-1:0] C1_HINT = '0,
  parameter int SNP_MIN = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NTHR-1:0]        halt_req,
  input  logic [NTHR-1:0]        wait_req,
  input  logic [NTHR*HINT_W-1:0] wait_hint,
  input  logic [NTHR-1:0]        iord_req,
  input  logic                   cfg_we,
  input  logic [HINT_W-1:0]      cfg_wdata,
  input  logic [NTHR-1:0]        smi_evt,
  input  logic [NTHR-1:0]        init_evt,
  input  logic [NTHR-1:0]        nmi_evt,
  input  logic [NTHR-1:0]        intr_evt,
  input  logic [NTHR-1:0]        msg_evt,
  input  logic [NTHR-1:0]        mon_evt,
  input  logic                   bus_snoop,
  input  logic [NTHR-1:0]        peer_snoop,
  input  logic [NTHR-1:0]        snoop_done,
  output logic [2*NTHR-1:0]      thr_state,
  output logic [1:0]             pkg_state,
  output logic                   pkg_idle
);
  logic [NTHR-1:0] wait_c1;
  logic [NTHR-1:0] hard_wake;

  assign hard_wake = smi_evt | init_evt | nmi_evt | intr_evt | msg_evt;

  cs_iord_xlate #(.NTHR(NTHR), .HINT_W(HINT_W), .C1_HINT(C1_HINT)) u_xlate (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .wait_req(wait_req), .wait_hint(wait_hint), .iord_req(iord_req),
    .wait_c1(wait_c1)
  );

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    cstate_e st;
    cs_thread_fsm #(.SNP_MIN(SNP_MIN)) u_fsm (
      .clk(clk), .rst(rst), .hard_wake(hard_wake[t]), .mon_evt(mon_evt[t]),
      .halt_req(halt_req[t]), .wait_c1(wait_c1[t]),
      .snoop(bus_snoop | peer_snoop[t]), .snoop_done(snoop_done[t]),
      .state(st)
    );
    assign thr_state[2*t +: 2] = st;
  end

  cs_pkg_resolve #(.NTHR(NTHR)) u_pkg (
    .clk(clk), .rst(rst), .thr_state(thr_state),
    .pkg_state(pkg_state), .pkg_idle(pkg_idle)
  );
endmodule

// File: rtl/cstate_coord_chk.sv
module cstate_coord_chk #(
  parameter int NTHR = 2
) (
  input logic                clk,
  input logic                rst,
  input logic [NTHR-1:0]     halt_req,
  input logic [NTHR-1:0]     smi_evt,
  input logic [NTHR-1:0]     init_evt,
  input logic [NTHR-1:0]     nmi_evt,
  input logic [NTHR-1:0]     intr_evt,
  input logic [NTHR-1:0]     msg_evt,
  input logic [NTHR-1:0]     mon_evt,
  input logic                bus_snoop,
  input logic [NTHR-1:0]     peer_snoop,
  input logic [2*NTHR-1:0]   thr_state,
  input logic [1:0]          pkg_state,
  input logic                pkg_idle
);
  logic [NTHR-1:0] hw;
  assign hw = smi_evt | init_evt | nmi_evt | intr_evt | msg_evt;

  a_r1_reset_run: assert property (@(posedge clk)
    rst |=> (thr_state == '0 && !pkg_idle));

  a_r10_idle_needs_low: assert property (@(posedge clk) disable iff (rst)
    pkg_idle |-> (pkg_state != 2'b00));

  for (genvar t = 0; t < NTHR; t++) begin : g_t
    logic [1:0] st;
    logic       sn;
    assign st = thr_state[2*t +: 2];
    assign sn = bus_snoop | peer_snoop[t];

    a_r3_wake_to_run: assert property (@(posedge clk) disable iff (rst)
      (st != 2'b00 && hw[t]) |=> (thr_state[2*t +: 2] == 2'b00));

    a_r4_halt_ignores_mon: assert property (@(posedge clk) disable iff (rst)
      (st == 2'b01 && mon_evt[t] && !hw[t] && !sn) |=> (thr_state[2*t +: 2] == 2'b01));

    a_r5_wake_drops_req: assert property (@(posedge clk) disable iff (rst)
      (st == 2'b00 && hw[t] && halt_req[t]) |=> (thr_state[2*t +: 2] == 2'b00));

    a_r6_snoop_entry: assert property (@(posedge clk) disable iff (rst)
      ((st == 2'b01 || st == 2'b10) && sn && !hw[t] && !mon_evt[t])
        |=> (thr_state[2*t +: 2] == 2'b11));

    a_r7_snoop_min_two: assert property (@(posedge clk) disable iff (rst)
      (st == 2'b11 && $past(thr_state[2*t +: 2]) != 2'b11 && !hw[t] && !mon_evt[t])
        |=> (thr_state[2*t +: 2] == 2'b11));

    if (t > 0) begin : g_split
      a_r9_split_is_run: assert property (@(posedge clk) disable iff (rst)
        (st != thr_state[1:0]) |-> (pkg_state == 2'b00));
    end
  end
endmodule

bind cstate_coord cstate_coord_chk #(.NTHR(NTHR)) u_chk (
  .clk(clk), .rst(rst), .halt_req(halt_req),
  .smi_evt(smi_evt), .init_evt(init_evt), .nmi_evt(nmi_evt),
  .intr_evt(intr_evt), .msg_evt(msg_evt), .mon_evt(mon_evt),
  .bus_snoop(bus_snoop), .peer_snoop(peer_snoop),
  .thr_state(thr_state), .pkg_state(pkg_state), .pkg_idle(pkg_idle)
);

// File: tb/test_cstate_coord.sv
module test_cstate_coord;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] halt_req = '0, wait_req = '0, iord_req = '0;
  logic [7:0] wait_hint = '0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_wdata = '0;
  logic [1:0] smi_evt = '0, init_evt = '0, nmi_evt = '0, intr_evt = '0, msg_evt = '0;
  logic [1:0] mon_evt = '0, peer_snoop = '0, snoop_done = '0;
  logic       bus_snoop = 1'b0;
  logic [3:0] thr_state;
  logic [1:0] pkg_state;
  logic       pkg_idle;

  int n_cmp = 0, n_bad = 0;
  bit run_cmp = 0, finished = 0;

  always #2.5ns clk = ~clk;

  cstate_coord i_cstate_coord (
    .clk(clk), .rst(rst), .halt_req(halt_req), .wait_req(wait_req),
    .wait_hint(wait_hint), .iord_req(iord_req), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .smi_evt(smi_evt), .init_evt(init_evt),
    .nmi_evt(nmi_evt), .intr_evt(intr_evt), .msg_evt(msg_evt),
    .mon_evt(mon_evt), .bus_snoop(bus_snoop), .peer_snoop(peer_snoop),
    .snoop_done(snoop_done), .thr_state(thr_state), .pkg_state(pkg_state),
    .pkg_idle(pkg_idle)
  );

  // ---------------- behavioural reference model ----------------
  int ms[2];
  int mcnt[2];
  bit mfrom_wait[2], mdone[2];
  int mcfg;
  bit midle;

  function automatic bit both_low(int a, int b);
    return (a == b) && (a == 1 || a == 2);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      ms[0] = 0; ms[1] = 0; mcfg = 0; midle = 0;
    end else begin
      midle = both_low(ms[0], ms[1]);
      for (int t = 0; t < 2; t++) begin
        bit wake, snp, wq;
        wake = smi_evt[t] | init_evt[t] | nmi_evt[t] | intr_evt[t] | msg_evt[t];
        snp  = bus_snoop | peer_snoop[t];
        wq   = (wait_req[t] && wait_hint[4*t +: 4] == 4'd0) || (iord_req[t] && mcfg == 0);
        if (ms[t] == 0) begin
          if (!wake && halt_req[t]) ms[t] = 1;
          else if (!wake && wq)     ms[t] = 2;
        end else if (ms[t] == 1 || ms[t] == 2) begin
          if (wake || (ms[t] == 2 && mon_evt[t])) ms[t] = 0;
          else if (snp) begin
            mfrom_wait[t] = (ms[t] == 2); mcnt[t] = 0; mdone[t] = 0; ms[t] = 3;
          end
        end else begin
          if (wake || (mfrom_wait[t] && mon_evt[t])) ms[t] = 0;
          else if (mcnt[t] >= 1 && (mdone[t] || snoop_done[t])) ms[t] = mfrom_wait[t] ? 2 : 1;
          else begin
            if (mcnt[t] < 1) mcnt[t]++;
            mdone[t] = mdone[t] | snoop_done[t];
          end
        end
      end
      if (cfg_we) mcfg = int'(cfg_wdata);
    end
  end

  task automatic chk(input string tag, input logic [3:0] es, input logic [1:0] ep, input logic ei);
    n_cmp++;
    if (thr_state !== es || pkg_state !== ep || pkg_idle !== ei) begin
      n_bad++;
      $display("FAIL %s: actual st=%b pkg=%b idle=%b expected st=%b pkg=%b idle=%b",
               tag, thr_state, pkg_state, pkg_idle, es, ep, ei);
    end
  endtask

  always @(negedge clk) begin
    if (run_cmp) begin
      logic [3:0] es;
      logic       low;
      low = both_low(ms[0], ms[1]);
      es  = {2'(ms[1]), 2'(ms[0])};
      chk("model R2/R3/R4/R5/R6/R7/R8/R9/R10", es, low ? 2'(ms[0]) : 2'b00, midle && low);
    end
  end

  task automatic clr();
    halt_req = '0; wait_req = '0; iord_req = '0; wait_hint = '0; cfg_we = 1'b0;
    smi_evt = '0; init_evt = '0; nmi_evt = '0; intr_evt = '0; msg_evt = '0;
    mon_evt = '0; bus_snoop = 1'b0; peer_snoop = '0; snoop_done = '0;
  endtask

  task automatic cyc();
    @(negedge clk);
    clr();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    // R1: reset overrides a halt request
    halt_req = 2'b11;
    repeat (3) @(negedge clk);
    run_cmp = 1;
    chk("R1 reset", 4'b0000, 2'b00, 1'b0);
    rst = 1'b0; clr();

    halt_req = 2'b11;                    cyc(); chk("R2 halt entry", 4'b0101, 2'b01, 1'b0);
                                         cyc(); chk("R10 idle rise", 4'b0101, 2'b01, 1'b1);
    mon_evt = 2'b11;                     cyc(); chk("R4 halt ignores mon", 4'b0101, 2'b01, 1'b1);
    bus_snoop = 1'b1;                    cyc(); chk("R6 bus snoop", 4'b1111, 2'b00, 1'b0);
                                         cyc(); chk("R7 waits done", 4'b1111, 2'b00, 1'b0);
                                         cyc(); chk("R7 waits done", 4'b1111, 2'b00, 1'b0);
    snoop_done = 2'b11;                  cyc(); chk("R7 return halt", 4'b0101, 2'b01, 1'b0);
                                         cyc(); chk("R10 idle again", 4'b0101, 2'b01, 1'b1);
    intr_evt = 2'b01;                    cyc(); chk("R3 intr wake", 4'b0100, 2'b00, 1'b0);
    wait_req = 2'b01;                    cyc(); chk("R2 wait entry", 4'b0110, 2'b00, 1'b0);
    mon_evt = 2'b01;                     cyc(); chk("R4 mon wakes wait", 4'b0100, 2'b00, 1'b0);
    nmi_evt = 2'b10;                     cyc(); chk("R3 nmi wake", 4'b0000, 2'b00, 1'b0);
    halt_req = 2'b01; smi_evt = 2'b01;   cyc(); chk("R5 wake wins", 4'b0000, 2'b00, 1'b0);
    cfg_we = 1'b1; cfg_wdata = 4'd3;     cyc();
    iord_req = 2'b01;                    cyc(); chk("R8 non-C1 cfg hint", 4'b0000, 2'b00, 1'b0);
    cfg_we = 1'b1; cfg_wdata = 4'd0;     cyc();
    iord_req = 2'b01;                    cyc(); chk("R8 iord to wait", 4'b0010, 2'b00, 1'b0);
    peer_snoop = 2'b01;                  cyc(); chk("R6 peer snoop", 4'b0011, 2'b00, 1'b0);
    init_evt = 2'b01;                    cyc(); chk("R7 wake in snoop", 4'b0000, 2'b00, 1'b0);
    wait_req = 2'b10; wait_hint = 8'h50; cyc(); chk("R2 non-C1 hint", 4'b0000, 2'b00, 1'b0);
    halt_req = 2'b11; wait_req = 2'b11;  cyc(); chk("R2 halt beats wait", 4'b0101, 2'b01, 1'b0);
    msg_evt = 2'b11;                     cyc(); chk("R3 msg wake", 4'b0000, 2'b00, 1'b0);
    wait_req = 2'b11;                    cyc(); chk("R9 both wait", 4'b1010, 2'b10, 1'b0);
                                         cyc(); chk("R10 idle wait", 4'b1010, 2'b10, 1'b1);
    halt_req = 2'b11;                    cyc(); chk("R6 req ignored in C1", 4'b1010, 2'b10, 1'b1);
    peer_snoop = 2'b10;                  cyc(); chk("R10 idle fall", 4'b1110, 2'b00, 1'b0);
    snoop_done = 2'b10;                  cyc(); chk("R7 min two cycles", 4'b1110, 2'b00, 1'b0);
                                         cyc(); chk("R7 return wait", 4'b1010, 2'b10, 1'b0);

    // random phase against the reference model
    for (int i = 0; i < 4000; i++) begin
      cyc();
      rst        = ($urandom_range(0, 299) == 0);
      halt_req   = 2'($urandom_range(0, 3)) & 2'($urandom_range(0, 3));
      wait_req   = 2'($urandom_range(0, 3)) & 2'($urandom_range(0, 3));
      wait_hint  = ($urandom_range(0, 3) == 0) ? 8'h33 : 8'h00;
      iord_req   = 2'($urandom_range(0, 3)) & 2'($urandom_range(0, 3));
      cfg_we     = ($urandom_range(0, 31) == 0);
      cfg_wdata  = ($urandom_range(0, 1) == 0) ? 4'd0 : 4'd5;
      smi_evt    = ($urandom_range(0, 39) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      init_evt   = ($urandom_range(0, 39) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      nmi_evt    = ($urandom_range(0, 39) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      intr_evt   = ($urandom_range(0, 39) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      msg_evt    = ($urandom_range(0, 39) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      mon_evt    = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      bus_snoop  = ($urandom_range(0, 11) == 0);
      peer_snoop = ($urandom_range(0, 11) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      snoop_done = 2'($urandom_range(0, 3)) & 2'($urandom_range(0, 3));
    end
    rst = 1'b0;
    cyc();
    cyc();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    #200us;
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R1: actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule